// File: doc/BRIEF.md
# YCbCr Capture and RGB Conversion

This block receives interlaced digital video from a 16-bit bus running on the video pixel clock. Each active beat carries one luma byte on the upper half and one chroma byte on the lower half. The block rebuilds a full YCbCr triple for every luma sample, from either 4:2:2 or 4:1:1 chroma subsampling. It then converts the triple to 24-bit RGB with a fixed matrix, using 128-centred chroma and fixed-point coefficients scaled by 1024.

A line qualifier marks the beats that belong to the active part of a line. The block emits one RGB pixel per captured luma sample, with a valid strobe, and delays a copy of the line qualifier to match. A chroma group is only usable once all of its beats have arrived. Pixels of a group cut short by the end of a line are therefore never marked valid.

Top module: `ycc_rgb_capture`

## Requirements
- R1: While reset is high and on the first cycle after it, all colour outputs are 0 and `px_valid` and `line_flag` are low.
- R2: The bus is sampled on rising clock edges only while `line_act` is high. Bus values while `line_act` is low change no output.
- R3: With `fmt_411` = 0 (4:2:2), the group length N is 2. Bits 15:8 of every beat carry Y. Bits 7:0 carry Cb on beats 0, 2, 4, … of the line and Cr on beats 1, 3, 5, …. Each Cb/Cr pair serves the two luma samples of its own two beats.
- R4: With `fmt_411` = 1 (4:1:1), N is 4. Bits 15:8 carry Y. Bits 7:0 of the first beat of each group of four carry Cb, and of the second beat carry Cr. Bits 7:0 of the third and fourth beats are ignored. The pair serves all four luma samples of the group.
- R5: With dr = Cr−128 and db = Cb−128, the outputs are computed with arithmetic (floor) shifts as follows. R = (1024·Y + 1404·dr + 512) >>> 10. G = (1024·Y − 715·dr − 344·db + 512) >>> 10. B = (1024·Y + 1774·db + 512) >>> 10.
- R6: Each colour result is saturated to the range 0 to 255 after the arithmetic.
- R7: A beat sampled at rising edge t drives its pixel onto the outputs after edge t+N+2, with `px_valid` high for exactly that cycle.
- R8: `line_flag` equals `line_act` as sampled N+2 edges earlier.
- R9: Luma samples of a trailing group that the line ends before completing produce no `px_valid`.
- R10: While `px_valid` is low, `r_out`, `g_out` and `b_out` keep their last values.
- R11: `fmt_411` changes only while `line_act` is low and no pixel is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Video pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_act | input | 1 | High on beats inside the active line |
| vid_data | input | 16 | Luma in bits 15:8, chroma in bits 7:0 |
| fmt_411 | input | 1 | 0 selects 4:2:2, 1 selects 4:1:1 |
| r_out | output | 8 | Red result |
| g_out | output | 8 | Green result |
| b_out | output | 8 | Blue result |
| px_valid | output | 1 | One-cycle strobe per converted pixel |
| line_flag | output | 1 | Line qualifier delayed to match the pixels |

## Verification
A beat sampled at edge t is due on the outputs after edge t+4 in 4:2:2 and after edge t+6 in 4:1:1. The same offset applies to the delayed line flag. When the bench drives a beat, it writes the expected strobe, flag and colour into a ring slot at that offset from the edge that will sample it. It reads the slot back after the matching edge, sampling on the falling clock edge. Cycles without a strobe expect the previously checked colour. This makes every idle cycle, including those with random bus values, a check of the hold and ignore rules.

// File: rtl/ycc_pkg.sv
`timescale 1ns/1ps
package ycc_pkg;
  localparam int PW      = 8;
  localparam int RES_W   = PW + 4;
  localparam int GRP_422 = 2;
  localparam int GRP_411 = 4;
  localparam int PH_W    = $clog2(GRP_411);

  typedef struct packed {
    logic          act;
    logic          vld;
    logic [PW-1:0] y;
    logic [PW-1:0] cb;
    logic [PW-1:0] cr;
  } ycc_pix_t;

  localparam logic signed [RES_W-1:0] SAT_HI = RES_W'((1 << PW) - 1);

  // saturate a signed intermediate into the pixel range
  function automatic logic [PW-1:0] clamp_pix(input logic signed [RES_W-1:0] v);
    if (v < 0)           return '0;
    else if (v > SAT_HI) return '1;
    else                 return v[PW-1:0];
  endfunction
endpackage

// File: rtl/ycc_chroma_align.sv
`timescale 1ns/1ps
module ycc_chroma_align
  import ycc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          line_act,
  input  logic [2*PW-1:0] vid_data,
  input  logic          fmt_411,
  output ycc_pix_t      pix_o
);
  localparam int CRD_W = $clog2(2*GRP_411 + 1);

  logic [PW-1:0]      y_sr [GRP_411];
  logic [GRP_411-1:0] act_sr;
  logic [PH_W-1:0]    phase, last_ph;
  logic [PW-1:0]      cb_hold, cr_hold, cb_grp, cr_grp;
  logic [CRD_W-1:0]   credit, grp_len;
  logic               last_beat, al_act, al_vld;
  logic [PW-1:0]      al_y;

  always_comb begin
    last_ph   = fmt_411 ? PH_W'(GRP_411-1) : PH_W'(GRP_422-1);
    grp_len   = fmt_411 ? CRD_W'(GRP_411) : CRD_W'(GRP_422);
    last_beat = line_act && (phase == last_ph);
    // luma leaves the delay line once its whole group has been sampled
    al_y      = y_sr[last_ph];
    al_act    = act_sr[last_ph];
    al_vld    = al_act && (credit != '0);
  end

  // luma delay line: no reset so it maps onto shift-register resources
  always_ff @(posedge clk) begin
    y_sr[0] <= vid_data[2*PW-1:PW];
    for (int i = 1; i < GRP_411; i++) y_sr[i] <= y_sr[i-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_sr  <= '0;
      phase   <= '0;
      cb_hold <= '0;
      cr_hold <= '0;
      cb_grp  <= '0;
      cr_grp  <= '0;
      credit  <= '0;
    end else begin
      act_sr <= {act_sr[GRP_411-2:0], line_act};
      if (!line_act)     phase <= '0;
      else if (last_beat) phase <= '0;
      else               phase <= phase + 1'b1;
      if (line_act && phase == PH_W'(0)) cb_hold <= vid_data[PW-1:0];
      if (line_act && phase == PH_W'(1)) cr_hold <= vid_data[PW-1:0];
      if (last_beat) begin
        cb_grp <= cb_hold;
        cr_grp <= fmt_411 ? cr_hold : vid_data[PW-1:0];
      end
      // each completed group licenses exactly its own luma samples
      credit <= credit + (last_beat ? grp_len : '0) - CRD_W'(al_vld);
    end
  end

  always_comb begin
    pix_o.act = al_act;
    pix_o.vld = al_vld;
    pix_o.y   = al_y;
    pix_o.cb  = cb_grp;
    pix_o.cr  = cr_grp;
  end

  // R9: licenses never pile up beyond two groups
  p_credit_bound_r9: assert property (@(posedge clk) disable iff (rst)
    credit <= CRD_W'(2*GRP_411));
endmodule

// File: rtl/ycc_matrix.sv
`timescale 1ns/1ps
module ycc_matrix
  import ycc_pkg::*;
#(
  parameter int FRAC = 10
)(
  input  logic          clk,
  input  logic          rst,
  input  ycc_pix_t      pix_i,
  output logic [PW-1:0] r_o,
  output logic [PW-1:0] g_o,
  output logic [PW-1:0] b_o,
  output logic          vld_o,
  output logic          act_o
);
  localparam int MW    = PW + FRAC + 4;
  localparam int SCALE = 1 << FRAC;
  localparam int CTR   = 1 << (PW-1);
  localparam logic signed [MW-1:0] K_RV = MW'((1371*SCALE + 500) / 1000);
  localparam logic signed [MW-1:0] K_GV = MW'((698*SCALE + 500) / 1000);
  localparam logic signed [MW-1:0] K_GU = MW'((336*SCALE + 500) / 1000);
  localparam logic signed [MW-1:0] K_BU = MW'((1732*SCALE + 500) / 1000);
  localparam logic signed [MW-1:0] HALF = MW'(SCALE / 2);

  logic signed [MW-1:0]    d_cb, d_cr, y_sc;
  logic signed [MW-1:0]    s1_y, s1_r, s1_g, s1_b;
  logic signed [RES_W-1:0] s2_r, s2_g, s2_b;
  logic                    s1_vld, s1_act, s2_vld, s2_act;

  always_comb begin
    d_cb = $signed(MW'(pix_i.cb)) - MW'(CTR);
    d_cr = $signed(MW'(pix_i.cr)) - MW'(CTR);
    y_sc = ($signed(MW'(pix_i.y)) <<< FRAC) + HALF;
  end

  // stage 1: products; stage 2: sums and rescale (data path without reset)
  always_ff @(posedge clk) begin
    s1_y <= y_sc;
    s1_r <= K_RV * d_cr;
    s1_g <= MW'(0) - K_GV * d_cr - K_GU * d_cb;
    s1_b <= K_BU * d_cb;
    s2_r <= RES_W'((s1_y + s1_r) >>> FRAC);
    s2_g <= RES_W'((s1_y + s1_g) >>> FRAC);
    s2_b <= RES_W'((s1_y + s1_b) >>> FRAC);
  end

  // stage 3: saturation into registered outputs, held between pixels
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_act <= 1'b0;
      s2_vld <= 1'b0;
      s2_act <= 1'b0;
      vld_o  <= 1'b0;
      act_o  <= 1'b0;
      r_o    <= '0;
      g_o    <= '0;
      b_o    <= '0;
    end else begin
      s1_vld <= pix_i.vld;
      s1_act <= pix_i.act;
      s2_vld <= s1_vld;
      s2_act <= s1_act;
      vld_o  <= s2_vld;
      act_o  <= s2_act;
      if (s2_vld) begin
        r_o <= clamp_pix(s2_r);
        g_o <= clamp_pix(s2_g);
        b_o <= clamp_pix(s2_b);
      end
    end
  end

  // R7: a pixel entering the matrix keeps moving one stage per cycle
  p_stage_chain_r7: assert property (@(posedge clk) disable iff (rst)
    s1_vld |=> s2_vld);
endmodule

// File: rtl/ycc_rgb_capture.sv
`timescale 1ns/1ps
module ycc_rgb_capture
  import ycc_pkg::*;
#(
  parameter int COEF_FRAC = 10
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          line_act,
  input  logic [15:0]   vid_data,
  input  logic          fmt_411,
  output logic [7:0]    r_out,
  output logic [7:0]    g_out,
  output logic [7:0]    b_out,
  output logic          px_valid,
  output logic          line_flag
);
  ycc_pix_t al_pix;

  ycc_chroma_align i_align (
    .clk      (clk),
    .rst      (rst),
    .line_act (line_act),
    .vid_data (vid_data),
    .fmt_411  (fmt_411),
    .pix_o    (al_pix)
  );

  ycc_matrix #(.FRAC(COEF_FRAC)) i_matrix (
    .clk   (clk),
    .rst   (rst),
    .pix_i (al_pix),
    .r_o   (r_out),
    .g_o   (g_out),
    .b_o   (b_out),
    .vld_o (px_valid),
    .act_o (line_flag)
  );

  // R8: a pixel strobe only occurs inside the delayed line window
  p_flag_covers_valid_r8: assert property (@(posedge clk) disable iff (rst)
    px_valid |-> line_flag);

  // R10: colours stay put on cycles without a strobe
  p_hold_rgb_r10: assert property (@(posedge clk) disable iff (rst)
    !px_valid |-> $stable({r_out, g_out, b_out}));

  // R11: format select is steady inside an active line
  p_fmt_steady_r11: assert property (@(posedge clk) disable iff (rst)
    (line_act && $past(line_act)) |-> $stable(fmt_411));
endmodule

// File: tb/test_ycc_rgb_capture.sv
`timescale 1ns/1ps
module test_ycc_rgb_capture;
  localparam int CLK_PERIOD = 10;
  localparam int RING = 32;

  logic clk = 1'b0, rst = 1'b1, line_act = 1'b0, fmt_411 = 1'b0;
  logic [15:0] vid_data = '0;
  logic [7:0]  r_out, g_out, b_out;
  logic        px_valid, line_flag;

  int cyc = 0, n_chk = 0, n_fail = 0;
  bit chk_on = 0, done = 0;
  logic        ev [RING];
  logic        ef [RING];
  logic [23:0] erg [RING];
  string       etag [RING];
  logic [23:0] last_rgb = '0;
  logic [7:0]  ybuf [64];
  logic [7:0]  lbuf [64];

  ycc_rgb_capture i_ycc_rgb_capture (
    .clk(clk), .rst(rst), .line_act(line_act), .vid_data(vid_data),
    .fmt_411(fmt_411), .r_out(r_out), .g_out(g_out), .b_out(b_out),
    .px_valid(px_valid), .line_flag(line_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int sat(input int v);
    if (v < 0) return 0;
    if (v > 255) return 255;
    return v;
  endfunction

  function automatic logic [23:0] ref_rgb(input int y, input int cb, input int cr);
    int dr, db, r, g, b;
    dr = cr - 128;
    db = cb - 128;
    r = (1024*y + 1404*dr + 512) >>> 10;
    g = (1024*y - 715*dr - 344*db + 512) >>> 10;
    b = (1024*y + 1774*db + 512) >>> 10;
    return {8'(sat(r)), 8'(sat(g)), 8'(sat(b))};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [23:0] got, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %06h expected %06h (cycle %0d)", req, what, got, exp, cyc);
    end
  endtask

  task automatic compare_now();
    int s;
    logic [23:0] got, exp;
    s = cyc % RING;
    got = {r_out, g_out, b_out};
    check(px_valid == ev[s], "R7/R9", "px_valid", 24'(px_valid), 24'(ev[s]));
    check(line_flag == ef[s], "R8", "line_flag", 24'(line_flag), 24'(ef[s]));
    if (ev[s]) begin
      exp = erg[s];
      check(got == exp, etag[s], "rgb", got, exp);
      last_rgb = exp;
    end else begin
      check(got == last_rgb, "R2/R10", "held rgb", got, last_rgb);
    end
    ev[s] = 1'b0; ef[s] = 1'b0; erg[s] = '0; etag[s] = "";
  endtask

  task automatic step(input logic act, input logic [15:0] d, input logic pv,
                      input logic [23:0] prgb, input string tag);
    int s;
    @(negedge clk);
    if (chk_on) compare_now();
    line_act = act;
    vid_data = d;
    s = (cyc + 1 + (fmt_411 ? 6 : 4)) % RING;
    ef[s] = act; ev[s] = pv; erg[s] = prgb; etag[s] = tag;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(1'b0, 16'($urandom), 1'b0, '0, "");
  endtask

  // sends ybuf/lbuf[0..n-1] as one line and schedules the expected pixels
  task automatic send_line(input bit f, input int n, input string tag);
    int nn, g0;
    bit full;
    fmt_411 = f;
    nn = f ? 4 : 2;
    for (int i = 0; i < n; i++) begin
      g0 = (i / nn) * nn;
      full = (g0 + nn <= n);
      step(1'b1, {ybuf[i], lbuf[i]}, full,
           ref_rgb(int'(ybuf[i]), int'(lbuf[g0]), int'(lbuf[g0+1])), tag);
    end
    idle(10);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    void'($urandom(32'd7719));
    for (int i = 0; i < RING; i++) begin
      ev[i] = 1'b0; ef[i] = 1'b0; erg[i] = '0; etag[i] = "";
    end
    // R1: reset state with a busy bus
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      line_act = 1'b1;
      vid_data = 16'($urandom);
      if (i > 1) begin
        check({r_out, g_out, b_out} == 24'h0, "R1", "rgb in reset", {r_out, g_out, b_out}, 24'h0);
        check(!px_valid && !line_flag, "R1", "strobes in reset", {22'h0, px_valid, line_flag}, 24'h0);
      end
    end
    @(negedge clk);
    line_act = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check({r_out, g_out, b_out, px_valid, line_flag} == 26'h0, "R1", "after reset",
          {r_out, g_out, b_out}, 24'h0);
    chk_on = 1;
    // R2: random bus while idle must leave outputs untouched
    idle(12);

    // R3: neutral chroma gives grey, then distinct pairs per two beats
    for (int i = 0; i < 8; i++) begin ybuf[i] = 8'(16 + 30*i); lbuf[i] = 8'd128; end
    send_line(1'b0, 8, "R3");
    ybuf[0] = 8'd100; ybuf[1] = 8'd100; ybuf[2] = 8'd100; ybuf[3] = 8'd100;
    lbuf[0] = 8'd200; lbuf[1] = 8'd50; lbuf[2] = 8'd60; lbuf[3] = 8'd210;
    send_line(1'b0, 4, "R3");

    // R4: one pair per four beats, third and fourth chroma bytes ignored
    for (int i = 0; i < 8; i++) ybuf[i] = 8'(40 + 20*i);
    lbuf[0] = 8'd40;  lbuf[1] = 8'd220; lbuf[2] = 8'd255; lbuf[3] = 8'd0;
    lbuf[4] = 8'd180; lbuf[5] = 8'd90;  lbuf[6] = 8'd1;   lbuf[7] = 8'd254;
    send_line(1'b1, 8, "R4");

    // R6: saturation at both ends
    ybuf[0] = 8'd255; lbuf[0] = 8'd255; ybuf[1] = 8'd255; lbuf[1] = 8'd255;
    ybuf[2] = 8'd0;   lbuf[2] = 8'd0;   ybuf[3] = 8'd0;   lbuf[3] = 8'd0;
    ybuf[4] = 8'd255; lbuf[4] = 8'd0;   ybuf[5] = 8'd0;   lbuf[5] = 8'd255;
    send_line(1'b0, 6, "R6");
    send_line(1'b1, 4, "R6");

    // R9: trailing partial groups
    for (int i = 0; i < 8; i++) begin ybuf[i] = 8'($urandom); lbuf[i] = 8'($urandom); end
    send_line(1'b0, 5, "R9");
    send_line(1'b1, 7, "R9");
    send_line(1'b1, 1, "R9");

    // R5: random lines in both formats (R11: format switched between lines)
    for (int l = 0; l < 10; l++) begin
      int n;
      n = 1 + int'($urandom % 40);
      for (int i = 0; i < 64; i++) begin ybuf[i] = 8'($urandom); lbuf[i] = 8'($urandom); end
      send_line(bit'($urandom % 2), n, "R5");
    end
    idle(8);
    done = 1;
    report();
  end
endmodule